// File: doc/BRIEF.md
# Serial-number arbitrated ID assignment

This block gives each of many identical devices on a shared two-wire bus its own 8-bit address at run time, instead of reading it from strap pins. Every device holds an ID register that doubles as its bus address. A broadcast clear command wipes the register in all devices at once. A following assign command makes every unaddressed device shift out its unique serial number on the open-drain data line, most significant bit first. Because the line is a wired-AND, a device that released the line but sees it low knows another device outranks it and withdraws. The one device left at the end captures the ID byte that the master sends next.

The block sits behind a bus front end that has already decoded start, stop and command bytes. It receives the control-code nibble with one-cycle clear and assign strobes, a strobe on each rising clock edge of the bus with the sampled data bit, and its own serial number. It returns a pull-down enable for the data pad, the current ID byte and a flag saying whether an ID has been given. Repeated assign rounds hand out IDs one device at a time, lowest serial number first.

Top module: `idAssign`

## Requirements
- R1: After reset the ID byte is 0, the assigned flag is 0 and the pull-down enable is 0.
- R2: Clear and assign strobes take effect only when the control-code input equals 4'b0110; with any other code they change neither the ID byte, the assigned flag nor the pull-down enable.
- R3: A clear strobe with the valid code sets the ID byte to 0 and the assigned flag to 0 from the next cycle, and abandons any arbitration or ID capture in progress.
- R4: An assign strobe with the valid code, given to an unassigned device, starts arbitration: for each of the serial-number bits, most significant first, the pull-down enable is 1 exactly while the current serial bit is 0.
- R5: On a bus rising-edge strobe during arbitration, a device whose current serial bit is 1 while the sampled data bit is 0 loses: from the next cycle it releases the line, keeps ID 0 and the assigned flag 0, and takes no further part in that round.
- R6: A device that survives all serial bits samples the data bit on the next 8 rising-edge strobes, most significant first; after the last one its ID byte equals the sampled byte and its assigned flag is 1.
- R7: A device whose assigned flag is 1 ignores assign strobes: it never pulls the line and its ID byte stays unchanged until a valid clear.
- R8: With distinct serial numbers, each assign round gives an ID to exactly one unassigned device, the one with the numerically lowest serial number.
- R9: The pull-down enable is 0 outside arbitration, in particular while the ID byte is being sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrlCode | input | 4 | Upper nibble of the decoded control byte |
| clearStb | input | 1 | One-cycle strobe: clear-address command decoded |
| assignStb | input | 1 | One-cycle strobe: assign-address command decoded |
| sclRise | input | 1 | One-cycle strobe per rising edge of the bus clock |
| sdaIn | input | 1 | Data line level sampled at that rising edge |
| serialNum | input | SN_W | Unique serial number of this device |
| sdaPullDown | output | 1 | Open-drain enable: 1 pulls the data line low |
| idByte | output | ID_W | Current ID (bus address) of the device |
| assigned | output | 1 | 1 once the device has won an ID |

## Verification
Assertions watch on every cycle that a valid clear empties the ID, that an assigned ID stays frozen without a clear, that an idle controller ignores everything but a valid assign, that a loss on a rising edge returns the controller to idle, that a commit sets the assigned flag and that an assigned device never pulls the line. Which device wins a round, and whether the captured byte is the one the master sent, depend on the interplay of several devices on one wired-AND line, so only the bench's multi-device scenarios can show them; it sweeps 64 sets of four serial numbers through complete assignment sequences, plus wrong-code and mid-arbitration clear cases.

// File: rtl/idAssignPkg.sv
package idAssignPkg;

  // Control-code nibble that wakes the device
  localparam logic [3:0] WAKE_CODE = 4'b0110;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic arbOn;      // arbitration phase: drive own serial bit
    logic clearId;    // force ID register to the unassigned value
    logic clearFlag;  // drop the assigned flag
    logic shiftIn;    // shift sampled bit into the capture register
    logic commit;     // last ID bit: load ID and set assigned flag
  } ctlStb_t;

endpackage

// File: rtl/idAssignCtrl.sv
module idAssignCtrl
  import idAssignPkg::*;
#(
  parameter int SN_W = 32,
  parameter int ID_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              ctrlCode,
  input  logic                    clearStb,
  input  logic                    assignStb,
  input  logic                    sclRise,
  input  logic                    sdaIn,
  input  logic                    ownBit,
  input  logic                    assigned,
  output logic [$clog2(SN_W)-1:0] bitIdx,
  output ctlStb_t                 stb
);

  localparam int SN_IW = $clog2(SN_W);
  localparam int ID_IW = $clog2(ID_W);

  typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_LOAD} state_e;

  state_e           state;
  logic [ID_IW-1:0] loadCnt;
  logic             codeOk, clearOk, assignOk, lose;

  assign codeOk   = (ctrlCode == WAKE_CODE);
  assign clearOk  = clearStb  && codeOk;
  assign assignOk = assignStb && codeOk;
  assign lose     = ownBit && !sdaIn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitIdx  <= '0;
      loadCnt <= '0;
    end else if (clearOk) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (assignOk && !assigned) begin
          state  <= ST_ARB;
          bitIdx <= SN_IW'(SN_W - 1);
        end
        ST_ARB: if (sclRise) begin
          if (lose) begin
            state <= ST_IDLE;
          end else if (bitIdx == '0) begin
            state   <= ST_LOAD;
            loadCnt <= ID_IW'(ID_W - 1);
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
        ST_LOAD: if (sclRise) begin
          if (loadCnt == '0) state <= ST_IDLE;
          else               loadCnt <= loadCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.arbOn     = (state == ST_ARB);
    stb.clearFlag = clearOk;
    stb.clearId   = clearOk || (state == ST_ARB && sclRise && lose);
    stb.shiftIn   = (state == ST_LOAD) && sclRise && !clearOk;
    stb.commit    = (state == ST_LOAD) && sclRise && (loadCnt == '0) && !clearOk;
  end

  // R2: an idle controller leaves idle only on an assign with the wake code
  p_idle_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !(assignStb && ctrlCode == WAKE_CODE)) |=> state == ST_IDLE);

  // R5: a lost bit on a rising edge ends this device's round
  p_loss_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARB && sclRise && ownBit && !sdaIn && !clearOk) |=> state == ST_IDLE);

endmodule

// File: rtl/idAssignDp.sv
module idAssignDp
  import idAssignPkg::*;
#(
  parameter int SN_W = 32,
  parameter int ID_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctlStb_t                 stb,
  input  logic [$clog2(SN_W)-1:0] bitIdx,
  input  logic [SN_W-1:0]         serialNum,
  input  logic                    sdaIn,
  output logic                    ownBit,
  output logic                    sdaPullDown,
  output logic [ID_W-1:0]         idByte,
  output logic                    assigned
);

  localparam int SH_W = ID_W - 1;
  localparam logic [ID_W-1:0] UNASSIGNED = '0;

  logic [SH_W-1:0] shiftReg;

  assign ownBit      = serialNum[bitIdx];
  assign sdaPullDown = stb.arbOn && !ownBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      idByte   <= UNASSIGNED;
      assigned <= 1'b0;
    end else begin
      if (stb.shiftIn) shiftReg <= SH_W'({shiftReg, sdaIn});
      if (stb.clearId) begin
        idByte <= UNASSIGNED;
      end else if (stb.commit) begin
        idByte <= {shiftReg, sdaIn};
      end
      if (stb.clearFlag)   assigned <= 1'b0;
      else if (stb.commit) assigned <= 1'b1;
    end
  end

  // R6: a commit from the controller leaves the device assigned
  p_commit_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.commit |=> assigned);

endmodule

// File: rtl/idAssign.sv
module idAssign
  import idAssignPkg::*;
#(
  parameter int SN_W = 32,
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      ctrlCode,
  input  logic            clearStb,
  input  logic            assignStb,
  input  logic            sclRise,
  input  logic            sdaIn,
  input  logic [SN_W-1:0] serialNum,
  output logic            sdaPullDown,
  output logic [ID_W-1:0] idByte,
  output logic            assigned
);

  localparam int SN_IW = $clog2(SN_W);

  ctlStb_t          stb;
  logic [SN_IW-1:0] bitIdx;
  logic             ownBit;

  idAssignCtrl #(.SN_W(SN_W), .ID_W(ID_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrlCode(ctrlCode), .clearStb(clearStb),
    .assignStb(assignStb), .sclRise(sclRise), .sdaIn(sdaIn),
    .ownBit(ownBit), .assigned(assigned), .bitIdx(bitIdx), .stb(stb)
  );

  idAssignDp #(.SN_W(SN_W), .ID_W(ID_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .bitIdx(bitIdx),
    .serialNum(serialNum), .sdaIn(sdaIn), .ownBit(ownBit),
    .sdaPullDown(sdaPullDown), .idByte(idByte), .assigned(assigned)
  );

  // R3: a valid clear empties the ID and the flag
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clearStb && ctrlCode == WAKE_CODE) |=> (!assigned && idByte == '0));

  // R7: an assigned ID is frozen until a valid clear
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (assigned && !(clearStb && ctrlCode == WAKE_CODE)) |=> (assigned && $stable(idByte)));

  // R9: an assigned device never pulls the data line
  p_quiet_assigned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    assigned |-> !sdaPullDown);

endmodule

// File: tb/test_idAssign.sv
module test_idAssign;

  localparam int SN_W = 4;
  localparam int ID_W = 8;
  localparam int NDEV = 4;
  localparam int WATCHDOG_NS = 200000 * 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      ctrlCode = 4'b0110;
  logic            clearStb = 1'b0;
  logic            assignStb = 1'b0;
  logic            sclRise = 1'b0;
  logic            sdaIn = 1'b1;
  logic [SN_W-1:0] sn [NDEV];
  logic [NDEV-1:0] pd;
  logic [ID_W-1:0] idv [NDEV];
  logic [NDEV-1:0] asg;

  int  nChk = 0;
  int  nFail = 0;
  bit  finished = 1'b0;
  bit  expAsg [NDEV];
  int  expId [NDEV];

  always #4 clk = ~clk;

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    idAssign #(.SN_W(SN_W), .ID_W(ID_W)) i_idAssign (
      .clk(clk), .rst_n(rst_n), .ctrlCode(ctrlCode), .clearStb(clearStb),
      .assignStb(assignStb), .sclRise(sclRise), .sdaIn(sdaIn),
      .serialNum(sn[g]), .sdaPullDown(pd[g]), .idByte(idv[g]), .assigned(asg[g])
    );
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  task automatic sclPulse(input logic b);
    sdaIn   = b;
    sclRise = 1'b1;
    @(negedge clk);
    sclRise = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkAllIds(input string req);
    for (int k = 0; k < NDEV; k++) begin
      chk(req, $sformatf("dev%0d assigned", k), int'(asg[k]), int'(expAsg[k]));
      chk(req, $sformatf("dev%0d id", k), int'(idv[k]), expId[k]);
    end
  endtask

  task automatic strobe(input logic [3:0] code, input bit isClear);
    ctrlCode = code;
    if (isClear) clearStb = 1'b1; else assignStb = 1'b1;
    @(negedge clk);
    clearStb  = 1'b0;
    assignStb = 1'b0;
    ctrlCode  = 4'b0110;
  endtask

  task automatic validClear();
    strobe(4'b0110, 1'b1);
    for (int k = 0; k < NDEV; k++) begin expAsg[k] = 1'b0; expId[k] = 0; end
    checkAllIds("R3");
    chk("R3", "pull-down after clear", int'(pd), 0);
  endtask

  // One full assign round with arithmetic model of the wired-AND bus
  task automatic runRound(input int idVal);
    bit alive [NDEV];
    int win;
    int best;
    bit anyFree;
    win = -1; best = 1 << SN_W; anyFree = 1'b0;
    for (int k = 0; k < NDEV; k++) begin
      alive[k] = !expAsg[k];
      if (!expAsg[k]) begin
        anyFree = 1'b1;
        if (int'(sn[k]) < best) begin best = int'(sn[k]); win = k; end
      end
    end
    strobe(4'b0110, 1'b0);
    for (int b = SN_W - 1; b >= 0; b--) begin
      logic busBit;
      busBit = 1'b1;
      for (int k = 0; k < NDEV; k++) begin
        int ePd;
        ePd = (alive[k] && !sn[k][b]) ? 1 : 0;
        if (ePd == 1) busBit = 1'b0;
        chk(expAsg[k] ? "R7" : (alive[k] ? "R4" : "R5"),
            $sformatf("dev%0d pull-down bit%0d", k, b), int'(pd[k]), ePd);
      end
      for (int k = 0; k < NDEV; k++)
        if (sn[k][b] && !busBit) alive[k] = 1'b0;
      sclPulse(busBit);
    end
    for (int i = ID_W - 1; i >= 0; i--) begin
      chk("R9", $sformatf("pull-down during id bit%0d", i), int'(pd), 0);
      sclPulse(idVal[i]);
    end
    if (anyFree) begin
      expAsg[win] = 1'b1;
      expId[win]  = idVal;
      checkAllIds("R8");
      chk("R6", "winner id", int'(idv[win]), idVal);
    end else begin
      checkAllIds("R7");
    end
  endtask

  initial begin
    #(WATCHDOG_NS);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    for (int k = 0; k < NDEV; k++) begin sn[k] = SN_W'(k); expAsg[k] = 1'b0; expId[k] = 0; end
    repeat (3) @(negedge clk);
    checkAllIds("R1");
    chk("R1", "pull-down in reset", int'(pd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    checkAllIds("R1");
    chk("R1", "pull-down after reset", int'(pd), 0);

    // R2: assign with a wrong code starts nothing
    strobe(4'b0111, 1'b0);
    for (int b = 0; b < SN_W; b++) begin
      chk("R2", "pull-down after wrong-code assign", int'(pd), 0);
      sclPulse(1'b0);
    end
    for (int i = 0; i < ID_W; i++) sclPulse(1'b1);
    checkAllIds("R2");

    // R3: clear in the middle of arbitration aborts it
    strobe(4'b0110, 1'b0);
    sclPulse(1'b0);
    sclPulse(1'b0);
    validClear();
    for (int i = 0; i < ID_W + SN_W; i++) begin
      chk("R3", "pull-down after abort", int'(pd), 0);
      sclPulse(1'b1);
    end
    checkAllIds("R3");

    // Sweep of 64 serial-number sets, distinct within each set
    for (int si = 0; si < 64; si++) begin
      int a, s;
      a = si % 16;
      s = 2 * (si / 16) + 1;
      for (int k = 0; k < NDEV; k++) sn[k] = SN_W'((a + k * s) % 16);
      @(negedge clk);
      validClear();
      for (int r = 0; r < NDEV; r++) runRound(((si * NDEV + r) % 255) + 1);
      runRound(8'hA5);
    end

    // R2: clear with a wrong code leaves the IDs in place
    strobe(4'b1110, 1'b1);
    checkAllIds("R2");

    finishRun();
  end

endmodule